// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Acknowledge

This block collects up to 128 level-sensitive interrupt lines for a single processor. It raises one interrupt request towards that processor. A distributor half holds three state bits for every line: enable, pending and active. It also holds an 8-bit priority for every line. Software changes the state bits through paired set and clear register banks. A one bit in the write data acts on its line, and a zero bit leaves that line alone. The CPU-interface half picks the best pending, enabled, not-active line. It compares the priority of that line with a priority mask and with the running priority.

Software takes an interrupt by reading the acknowledge register. The read returns the interrupt ID, moves the line to the active state and records its priority in the active-priority record. Software retires the interrupt by writing the same ID to the end-of-interrupt register. The running priority comes from the lowest entry in the active-priority record, so a higher-priority line can pre-empt one that is being handled. Software can overwrite the record with zero to recover an interface that is stuck.

The interface request follows a three-state machine. CI_OFF is the state while the interface is disabled. CI_IDLE means enabled with nothing qualifying. CI_SIGNAL means the request is asserted. The transitions are:
- enable: CI_OFF to CI_IDLE.
- raise: CI_IDLE to CI_SIGNAL, when a line qualifies.
- take: CI_SIGNAL to CI_IDLE, on an acknowledge read.
- lose: CI_SIGNAL to CI_IDLE, when the line stops qualifying.
- disable: any state to CI_OFF.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The block has one register bus, and bus_addr[12] selects the window: 0 for the distributor, 1 for the CPU interface. A read returns its data on bus_rdata with bus_rvalid high exactly one cycle after the request. A write gives no response.
- R2: The distributor has six 32-bit banks, each one word per 32 lines (line n at word n/32, bit n%32): set-enable 0x100, clear-enable 0x180, set-pending 0x200, clear-pending 0x280, set-active 0x300, clear-active 0x380. Reads of a set bank or of its clear bank return the current bits. In a write, ones act and zeros change nothing.
- R3: The pending state of a line is its software latch OR (its input level AND its enable). Clear-pending clears only the latch, so the pending bit follows the level of an enabled line.
- R4: Priorities are one byte per line, four per word from offset 0x400, with line 4k+j in bits [8j+7:8j] of word k. They reset to 0.
- R5: The request is forwarded only when bit 0 of the distributor control word (0x000) and bit 0 of the interface control word (0x1000) are both set. Otherwise cpu_irq stays low and an acknowledge read returns 1023.
- R6: A line qualifies only if its priority is strictly below the mask at 0x1004 (reset 0).
- R7: Among candidates (enabled, pending, not active), the lowest priority value wins and a tie goes to the lowest ID. An active line is not offered, even while it is pending.
- R8: A read of 0x100C returns the winning ID in bits [9:0], with zeros above, and makes that line active and clears its software latch. When nothing qualifies, the read returns 1023 and changes nothing.
- R9: A write of an ID below 128 to 0x1010 clears that line's active bit and removes the lowest entry from the active-priority record. A line whose input is still high becomes pending again.
- R10: The running priority is readable at 0x1014. It is twice the index of the lowest set record bit, where an acknowledge sets bit priority/2, and it is 0xFF when the record is empty. A line must have a priority strictly below the running priority to be taken.
- R11: The four record words at 0x10D0, 0x10D4, 0x10D8 and 0x10DC (record bits 0-31, 32-63, 64-95, 96-127) read back and are replaced by writes. Writing zero to all four returns the running priority to 0xFF.
- R12: cpu_irq is registered. It rises when a line qualifies and falls in the cycle after that line is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 13 | Byte address; bit 12 selects the interface window |
| bus_wdata | input | 32 | Write data |
| irq_lines | input | 128 | Level-sensitive interrupt inputs |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench makes two lines of equal priority assert together. A design that broke ties by the highest ID, or that used a non-strict compare, would return the wrong ID there. It then nests a higher-priority interrupt inside a lower one and sends an equal-priority line while that one runs. A design that ignored the running priority would grant the equal line, and one that retired the wrong record entry would report the wrong running priority after end-of-interrupt. It also holds a line high across end-of-interrupt and sets the mask equal to the line's priority. This exposes a lost re-pend and an off-by-one mask compare. Finally it disables each of the two forwarding gates in turn and clears a stuck record by writing zero to it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int PRIO_W   = 8;
    localparam int ID_W     = 10;
    localparam int REC_BITS = 2 ** (PRIO_W - 1);
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        CI_OFF,
        CI_IDLE,
        CI_SIGNAL
    } ci_state_e;
endpackage

// File: rtl/irqc_dist.sv
module irqc_dist
    import irqc_pkg::*;
#(
    parameter int N_IRQ = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [11:0]             addr,
    input  logic [31:0]             wdata,
    input  logic [N_IRQ-1:0]        lines,
    input  logic                    ack_take,
    input  logic [ID_W-1:0]         ack_id,
    input  logic                    eoi_take,
    input  logic [ID_W-1:0]         eoi_id,
    output logic [31:0]             rdata,
    output logic                    dist_en,
    output logic [N_IRQ-1:0]        cand_vec,
    output logic [N_IRQ-1:0]        act_vec,
    output logic [N_IRQ*PRIO_W-1:0] prio_flat
);
    localparam int WORDS   = N_IRQ / 32;
    localparam int PWORDS  = N_IRQ / 4;
    localparam int WIDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int PIDX_W  = (PWORDS > 1) ? $clog2(PWORDS) : 1;

    logic [N_IRQ-1:0]  en_q, swp_q, act_q, pend_vec;
    logic [PRIO_W-1:0] prio_q [N_IRQ];
    logic              ctrl_q;

    logic [31:0] en_w   [WORDS];
    logic [31:0] pend_w [WORDS];
    logic [31:0] act_w  [WORDS];
    logic [31:0] prio_w [PWORDS];

    logic [4:0] bank;
    logic [4:0] widx;
    logic [7:0] pidx;
    logic       hit_seten, hit_clren, hit_setpnd, hit_clrpnd, hit_setact, hit_clract, hit_prio;
    logic [WORDS-1:0] word_hit;

    assign bank = addr[11:7];
    assign widx = addr[6:2];
    assign pidx = addr[9:2];

    assign hit_seten  = wr_en && (bank == 5'd2);
    assign hit_clren  = wr_en && (bank == 5'd3);
    assign hit_setpnd = wr_en && (bank == 5'd4);
    assign hit_clrpnd = wr_en && (bank == 5'd5);
    assign hit_setact = wr_en && (bank == 5'd6);
    assign hit_clract = wr_en && (bank == 5'd7);
    assign hit_prio   = wr_en && (addr[11:10] == 2'b01);

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_words
            assign word_hit[w] = (widx == 5'(w));
            assign en_w[w]     = en_q[32*w +: 32];
            assign pend_w[w]   = pend_vec[32*w +: 32];
            assign act_w[w]    = act_q[32*w +: 32];
        end
        for (genvar k = 0; k < PWORDS; k++) begin : g_pwords
            for (genvar j = 0; j < 4; j++) begin : g_bytes
                assign prio_w[k][8*j +: 8] = prio_q[4*k+j];
            end
        end
        for (genvar i = 0; i < N_IRQ; i++) begin : g_flat
            assign prio_flat[PRIO_W*i +: PRIO_W] = prio_q[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
        end else if (wr_en && (addr == 12'h000)) begin
            ctrl_q <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            swp_q <= '0;
            act_q <= '0;
        end else begin
            for (int i = 0; i < N_IRQ; i++) begin
                if (word_hit[i/32] && wdata[i%32]) begin
                    if (hit_seten)  en_q[i]  <= 1'b1;
                    if (hit_clren)  en_q[i]  <= 1'b0;
                    if (hit_setpnd) swp_q[i] <= 1'b1;
                    if (hit_clrpnd) swp_q[i] <= 1'b0;
                    if (hit_setact) act_q[i] <= 1'b1;
                    if (hit_clract) act_q[i] <= 1'b0;
                end
                if (ack_take && (ack_id == ID_W'(i))) begin
                    act_q[i]  <= 1'b1;
                    swp_q[i]  <= 1'b0;
                end
                if (eoi_take && (eoi_id == ID_W'(i))) begin
                    act_q[i]  <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_IRQ; i++) prio_q[i] <= '0;
        end else if (hit_prio) begin
            for (int i = 0; i < N_IRQ; i++) begin
                if (pidx == 8'(i/4)) prio_q[i] <= wdata[8*(i%4) +: 8];
            end
        end
    end

    assign pend_vec = swp_q | (lines & en_q);
    assign cand_vec = (en_q & pend_vec & ~act_q) & {N_IRQ{ctrl_q}};
    assign act_vec  = act_q;
    assign dist_en  = ctrl_q;

    always_comb begin
        rdata = 32'h0;
        if (addr == 12'h000) begin
            rdata = {31'h0, ctrl_q};
        end else if (addr[11:10] == 2'b01) begin
            if (32'(pidx) < PWORDS) rdata = prio_w[pidx[PIDX_W-1:0]];
        end else if (32'(widx) < WORDS) begin
            unique case (bank)
                5'd2, 5'd3: rdata = en_w[widx[WIDX_W-1:0]];
                5'd4, 5'd5: rdata = pend_w[widx[WIDX_W-1:0]];
                5'd6, 5'd7: rdata = act_w[widx[WIDX_W-1:0]];
                default:    rdata = 32'h0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int N_IRQ = 128
) (
    input  logic [N_IRQ-1:0]        cand_vec,
    input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
    output logic                    best_valid,
    output logic [ID_W-1:0]         best_id,
    output logic [PRIO_W-1:0]       best_prio
);
    always_comb begin
        best_valid = 1'b0;
        best_id    = SPURIOUS_ID;
        best_prio  = '1;
        for (int i = 0; i < N_IRQ; i++) begin
            if (cand_vec[i] && (!best_valid || (prio_flat[PRIO_W*i +: PRIO_W] < best_prio))) begin
                best_valid = 1'b1;
                best_id    = ID_W'(i);
                best_prio  = prio_flat[PRIO_W*i +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irqc_cpuif.sv
module irqc_cpuif
    import irqc_pkg::*;
#(
    parameter int N_IRQ = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [11:0]       addr,
    input  logic [31:0]       wdata,
    input  logic              best_valid,
    input  logic [ID_W-1:0]   best_id,
    input  logic [PRIO_W-1:0] best_prio,
    output logic [31:0]       rdata,
    output logic              ack_take,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_take,
    output logic [ID_W-1:0]   eoi_id,
    output logic              cpu_en,
    output logic [PRIO_W-1:0] mask,
    output logic [PRIO_W-1:0] run_prio,
    output logic              cpu_irq
);
    localparam int RIDX_W = PRIO_W - 1;

    ci_state_e            state_q, state_d;
    logic [1:0]           ctrl_q;
    logic [PRIO_W-1:0]    mask_q;
    logic [REC_BITS-1:0]  rec_q;
    logic [31:0]          rec_w [REC_BITS/32];
    logic                 rec_any;
    logic [RIDX_W-1:0]    rec_idx;
    logic                 qualify;
    logic                 apr_hit;

    generate
        for (genvar w = 0; w < REC_BITS/32; w++) begin : g_rec
            assign rec_w[w] = rec_q[32*w +: 32];
        end
    endgenerate

    always_comb begin
        rec_any = 1'b0;
        rec_idx = '0;
        for (int i = REC_BITS - 1; i >= 0; i--) begin
            if (rec_q[i]) begin
                rec_any = 1'b1;
                rec_idx = RIDX_W'(i);
            end
        end
    end

    assign run_prio = rec_any ? {rec_idx, 1'b0} : '1;
    assign qualify  = best_valid && ctrl_q[0] && (best_prio < mask_q) && (best_prio < run_prio);
    assign ack_take = rd_en && (addr == 12'h00C) && qualify;
    assign ack_id   = best_id;
    assign eoi_id   = wdata[ID_W-1:0];
    assign eoi_take = wr_en && (addr == 12'h010) && (32'(eoi_id) < N_IRQ);
    assign apr_hit  = wr_en && (addr[11:4] == 8'h0D);
    assign cpu_en   = ctrl_q[0];
    assign mask     = mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 2'b00;
            mask_q <= '0;
        end else if (wr_en) begin
            if (addr == 12'h000) ctrl_q <= wdata[1:0];
            if (addr == 12'h004) mask_q <= wdata[PRIO_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else if (apr_hit) begin
            rec_q[{addr[3:2], 5'b0} +: 32] <= wdata;
        end else if (ack_take) begin
            rec_q[best_prio[PRIO_W-1:1]] <= 1'b1;
        end else if (eoi_take && rec_any) begin
            rec_q[rec_idx] <= 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CI_OFF:    state_d = ctrl_q[0] ? CI_IDLE : CI_OFF;
            CI_IDLE:   begin
                if (!ctrl_q[0])    state_d = CI_OFF;
                else if (ack_take) state_d = CI_IDLE;
                else if (qualify)  state_d = CI_SIGNAL;
            end
            CI_SIGNAL: begin
                if (!ctrl_q[0])                state_d = CI_OFF;
                else if (ack_take || !qualify) state_d = CI_IDLE;
            end
            default:   state_d = CI_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CI_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        cpu_irq = (state_q == CI_SIGNAL);
    end

    always_comb begin
        rdata = 32'h0;
        unique case (addr)
            12'h000: rdata = {30'h0, ctrl_q};
            12'h004: rdata = {{(32-PRIO_W){1'b0}}, mask_q};
            12'h00C: rdata = {{(32-ID_W){1'b0}}, qualify ? best_id : SPURIOUS_ID};
            12'h014: rdata = {{(32-PRIO_W){1'b0}}, run_prio};
            12'h0D0: rdata = rec_w[0];
            12'h0D4: rdata = rec_w[1];
            12'h0D8: rdata = rec_w[2];
            12'h0DC: rdata = rec_w[3];
            default: rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_IRQ = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [12:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    input  logic [N_IRQ-1:0] irq_lines,
    output logic [31:0]      bus_rdata,
    output logic             bus_rvalid,
    output logic             cpu_irq
);
    localparam int IDX_W = $clog2(N_IRQ);

    logic                    sel_cpu, dist_wr, cpu_wr, cpu_rd;
    logic [31:0]             dist_rdata, cpu_rdata;
    logic                    dist_en, cpu_en;
    logic [N_IRQ-1:0]        cand_vec, act_vec;
    logic [N_IRQ*PRIO_W-1:0] prio_flat;
    logic                    best_valid;
    logic [ID_W-1:0]         best_id, ack_id, eoi_id;
    logic [PRIO_W-1:0]       best_prio, mask, run_prio;
    logic                    ack_take, eoi_take;
    logic [IDX_W-1:0]        ack_idx, eoi_idx;

    assign sel_cpu = bus_addr[12];
    assign dist_wr = bus_req && bus_we && !sel_cpu;
    assign cpu_wr  = bus_req && bus_we && sel_cpu;
    assign cpu_rd  = bus_req && !bus_we && sel_cpu;
    assign ack_idx = ack_id[IDX_W-1:0];
    assign eoi_idx = eoi_id[IDX_W-1:0];

    irqc_dist #(.N_IRQ(N_IRQ)) u_dist (
        .clk(clk), .rst_n(rst_n), .wr_en(dist_wr), .addr(bus_addr[11:0]),
        .wdata(bus_wdata), .lines(irq_lines), .ack_take(ack_take), .ack_id(ack_id),
        .eoi_take(eoi_take), .eoi_id(eoi_id), .rdata(dist_rdata), .dist_en(dist_en),
        .cand_vec(cand_vec), .act_vec(act_vec), .prio_flat(prio_flat)
    );

    irqc_arbiter #(.N_IRQ(N_IRQ)) u_arb (
        .cand_vec(cand_vec), .prio_flat(prio_flat), .best_valid(best_valid),
        .best_id(best_id), .best_prio(best_prio)
    );

    irqc_cpuif #(.N_IRQ(N_IRQ)) u_cpuif (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .rd_en(cpu_rd), .addr(bus_addr[11:0]),
        .wdata(bus_wdata), .best_valid(best_valid), .best_id(best_id), .best_prio(best_prio),
        .rdata(cpu_rdata), .ack_take(ack_take), .ack_id(ack_id), .eoi_take(eoi_take),
        .eoi_id(eoi_id), .cpu_en(cpu_en), .mask(mask), .run_prio(run_prio), .cpu_irq(cpu_irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= 32'h0;
        end else begin
            bus_rvalid <= bus_req && !bus_we;
            if (bus_req && !bus_we) bus_rdata <= sel_cpu ? cpu_rdata : dist_rdata;
        end
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int N_IRQ = 128,
    parameter int IDX_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_rvalid,
    input logic              cpu_irq,
    input logic              cpu_en,
    input logic              dist_en,
    input logic              ack_take,
    input logic [IDX_W-1:0]  ack_idx,
    input logic              eoi_take,
    input logic [IDX_W-1:0]  eoi_idx,
    input logic [N_IRQ-1:0]  act_vec,
    input logic [PRIO_W-1:0] best_prio,
    input logic [PRIO_W-1:0] mask
);
    assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    assert_write_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> !bus_rvalid);

    assert_ack_activates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> act_vec[$past(ack_idx)]);

    assert_eoi_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_take |=> !act_vec[$past(eoi_idx)]);

    assert_iface_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_en |=> !cpu_irq);

    assert_dist_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past(dist_en));

    assert_mask_below_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> ($past(best_prio) < $past(mask)));
endmodule

bind prio_irq_ctrl irqc_checker #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_rvalid(bus_rvalid),
    .cpu_irq(cpu_irq), .cpu_en(cpu_en), .dist_en(dist_en), .ack_take(ack_take),
    .ack_idx(ack_idx), .eoi_take(eoi_take), .eoi_idx(eoi_idx), .act_vec(act_vec),
    .best_prio(best_prio), .mask(mask)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    localparam int N = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req = 1'b0;
    logic         bus_we = 1'b0;
    logic [12:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [N-1:0] irq_lines = '0;
    logic [31:0]  bus_rdata;
    logic         bus_rvalid;
    logic         cpu_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    exp_t cur;

    always #5 clk = ~clk;

    prio_irq_ctrl #(.N_IRQ(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .irq_lines(irq_lines), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq)
    );

    // Monitor: pops the scoreboard whenever the design returns read data.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R1: unexpected read data %h, expected no response", bus_rdata);
            end else begin
                cur = sb_q.pop_front();
                if (bus_rdata !== cur.val) begin
                    fails++;
                    $display("FAIL %s: read %h expected %h", cur.tag, bus_rdata, cur.val);
                end
            end
        end
    end

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, input logic [31:0] e, input string tag);
        exp_t item;
        @(negedge clk);
        item.val = e; item.tag = tag;
        sb_q.push_back(item);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        repeat (3) @(negedge clk);
        checks++;
        if (cpu_irq !== e) begin
            fails++;
            $display("FAIL %s: cpu_irq %b expected %b", tag, cpu_irq, e);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (2000) @(negedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk_irq(1'b0, "R12 reset");
        rd(13'h100C, 32'd1023, "R8 spurious at reset");
        rd(13'h1014, 32'hFF, "R10 idle running priority");
        rd(13'h0400, 32'h0, "R4 priority reset");
        rd(13'h0000, 32'h0, "R5 distributor off at reset");

        // setup
        wr(13'h0000, 32'h1);
        wr(13'h1000, 32'h1);
        wr(13'h1004, 32'hFF);
        wr(13'h0404, 32'h10008000);   // line5=0x80, line7=0x10
        wr(13'h0408, 32'h00000020);   // line8=0x20
        wr(13'h0428, 32'h00004040);   // lines 40,41 = 0x40
        rd(13'h0428, 32'h00004040, "R4 priority byte packing");

        // enable with write-one semantics
        wr(13'h0100, 32'h20);
        wr(13'h0100, 32'h0);
        rd(13'h0100, 32'h20, "R2 set-enable, zero ignored");
        irq_lines[5] = 1'b1;
        chk_irq(1'b1, "R12 raised");
        rd(13'h0200, 32'h20, "R3 level pending");
        rd(13'h100C, 32'd5, "R8 acknowledge id");
        chk_irq(1'b0, "R12 dropped after acknowledge");
        rd(13'h0300, 32'h20, "R8 marked active");
        rd(13'h1014, 32'h80, "R10 running priority");
        rd(13'h100C, 32'd1023, "R7 active line not offered");
        wr(13'h1010, 32'd5);
        rd(13'h0300, 32'h0, "R9 end of interrupt clears active");
        rd(13'h1014, 32'hFF, "R9 record retired");
        rd(13'h100C, 32'd5, "R9 held line pends again");
        wr(13'h1010, 32'd5);
        irq_lines[5] = 1'b0;
        rd(13'h0200, 32'h0, "R3 pending follows level");

        // mask boundary
        irq_lines[5] = 1'b1;
        wr(13'h1004, 32'h80);
        rd(13'h100C, 32'd1023, "R6 mask equal blocks");
        chk_irq(1'b0, "R6 no request at equal mask");
        wr(13'h1004, 32'h81);
        chk_irq(1'b1, "R6 request below mask");
        rd(13'h100C, 32'd5, "R6 taken below mask");

        // tie and pre-emption
        wr(13'h0104, 32'h300);
        irq_lines[40] = 1'b1;
        irq_lines[41] = 1'b1;
        rd(13'h100C, 32'd40, "R7 tie to lowest id, R10 pre-empt");
        rd(13'h1014, 32'h40, "R10 nested running priority");
        rd(13'h100C, 32'd1023, "R10 equal priority cannot pre-empt");
        irq_lines[40] = 1'b0;
        wr(13'h1010, 32'd40);
        rd(13'h1014, 32'h80, "R9 lowest record entry retired");
        rd(13'h100C, 32'd41, "R7 next candidate");
        irq_lines[41] = 1'b0;
        wr(13'h1010, 32'd41);
        wr(13'h1010, 32'd5);
        rd(13'h1014, 32'hFF, "R10 idle after all retired");
        irq_lines[5] = 1'b0;
        wr(13'h1004, 32'hFF);

        // software pending latch
        wr(13'h0100, 32'h180);
        wr(13'h0200, 32'h100);
        rd(13'h0200, 32'h100, "R3 software set-pending");
        wr(13'h0280, 32'h100);
        rd(13'h0280, 32'h0, "R3 clear-pending");
        wr(13'h0200, 32'h80);
        rd(13'h100C, 32'd7, "R8 software pending taken");
        rd(13'h0200, 32'h0, "R8 latch cleared by acknowledge");
        wr(13'h1010, 32'd7);
        wr(13'h0180, 32'h100);
        rd(13'h0180, 32'hA0, "R2 clear-enable one bit");

        // active banks
        wr(13'h030C, 32'h10);
        rd(13'h030C, 32'h10, "R2 set-active");
        wr(13'h038C, 32'h10);
        rd(13'h038C, 32'h0, "R2 clear-active");

        // forwarding gates
        irq_lines[5] = 1'b1;
        chk_irq(1'b1, "R5 both gates on");
        wr(13'h0000, 32'h0);
        chk_irq(1'b0, "R5 distributor gate");
        rd(13'h100C, 32'd1023, "R5 spurious while distributor off");
        wr(13'h0000, 32'h1);
        wr(13'h1000, 32'h0);
        chk_irq(1'b0, "R5 interface gate");
        rd(13'h100C, 32'd1023, "R5 spurious while interface off");
        wr(13'h1000, 32'h1);
        chk_irq(1'b1, "R5 re-enabled");

        // record recovery
        rd(13'h100C, 32'd5, "R11 acknowledge before recovery");
        rd(13'h10D8, 32'h1, "R11 record word holds priority/2");
        wr(13'h10D0, 32'h0);
        wr(13'h10D4, 32'h0);
        wr(13'h10D8, 32'h0);
        wr(13'h10DC, 32'h0);
        rd(13'h1014, 32'hFF, "R11 cleared record idles");
        irq_lines[5] = 1'b0;
        wr(13'h0380, 32'h20);
        rd(13'h0300, 32'h0, "R2 active cleared after recovery");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d reads unanswered, expected 0", sb_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule